// File: doc/BRIEF.md
# Serial Register Configuration Port

This block is the slave side of the serial control port of a scanner sensor front end. A host frames each access by pulling an active-low enable, then clocks in sixteen bits: a direction bit, a three-bit register address, four pad bits and eight data bits. Address and data travel least significant bit first. A write lands in one of seven 8-bit registers: one configuration register, three gain registers (red, green, blue) and three offset registers (red, green, blue). A read sends the addressed register back during the data half of the same frame.

The port works with either of two wirings. With a single bidirectional data line, read data goes back on that line. With separate input and output lines, read data goes out on the output line. That output line doubles as a strap, and the block samples it while the first address bit arrives to learn which wiring the board uses. Pads are not modelled: each output line has a value and an enable.

All logic runs on one fast system clock. The serial clock, enable, data and strap inputs must already be synchronous to it. Register contents go to the analog datapath together with fields decoded from the configuration register: power-down, input span, sampling mode, input channel choice and monitor disable.

Top module: `sps_cfg_port`

## Requirements
- R1: A frame is 16 serial-clock rising edges while the enable is low. Bit 0 is direction (1 = read, 0 = write), bits 1..3 are address a0..a2, bits 4..7 are ignored and bits 8..15 are data d0..d7. A write updates the addressed register after bit 15 is sampled. Addresses: 0 configuration, 1/2/3 red/green/blue gain, 4/5/6 red/green/blue offset.
- R2: On a read, register bit d0..d7 is driven after the falling serial-clock edge that follows frame bits 7..14 respectively, so the host samples it at rising edge 8..15.
- R3: If the strap line is low when address bit a0 is sampled, read data appears on the bidirectional line and the separate output line stays undriven.
- R4: If the strap line is high when a0 is sampled, read data appears on the separate output line and the bidirectional line stays undriven.
- R5: Neither output line is enabled outside the read data phase, and both are released within one system clock after the enable goes high.
- R6: A frame ended by the enable going high before bit 15 writes no register.
- R7: A write to address 7 changes nothing, and a read of address 7 returns 0x00.
- R8: Writing the configuration register with bit 7 = 1 sets power-down and keeps bits 6:0. Writing it with bit 7 = 0 clears power-down and loads all eight bits.
- R9: Gain outputs carry bits 5:0 of each gain register. Bits 7:6 are kept and read back as written.
- R10: After reset every register is 0x00. Power-down, wide span, correlated mode and monitor disable are then low, and the channel choice is 00.
- R11: The two output enables are never high at the same time.
- R12: The decoded outputs follow the configuration register: span_hi = bit 0, cds_en = bit 1, in_sel = bits 3:2, mon_off = bit 5, power_down = bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sen_n | input | 1 | Frame enable, active low |
| sdio_in | input | 1 | Serial data in (bidirectional line in one wiring, input line in the other) |
| sdio_out | output | 1 | Read data toward the bidirectional line |
| sdio_oe | output | 1 | Drive enable of the bidirectional line |
| sdo_in | input | 1 | Level seen on the output/strap line |
| sdo_out | output | 1 | Read data toward the separate output line |
| sdo_oe | output | 1 | Drive enable of the separate output line |
| cfg_word | output | 8 | Configuration register |
| gain_codes | output | 18 | Gain codes, red in [5:0], green [11:6], blue [17:12] |
| offset_codes | output | 24 | Offset registers, red in [7:0], green [15:8], blue [23:16] |
| power_down | output | 1 | Power-down request |
| span_hi | output | 1 | Wide input span selected |
| cds_en | output | 1 | Correlated double sampling selected |
| in_sel | output | 2 | Input channel choice |
| mon_off | output | 1 | Analog monitor disabled |

## Verification
The hardest states to reach are those a well-behaved host never produces: a frame cut off one bit before its write commits, a read cut off in the middle of its data phase, and a power-down write that arrives while the lower configuration bits hold non-zero values. The bench reaches them with one frame task that takes a bit count and a wiring choice, so it can end any frame at any bit and flip the strap between frames. Each frame is followed by a readback, which shows the abort or the partial update at the ports.

// File: rtl/sps_pkg.sv
// Package: shared constants and the register address type of the serial
// configuration port. Assumes a 16-bit frame with 3 address bits.
package sps_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG    = 3'd0,
        RA_GAIN_R = 3'd1,
        RA_GAIN_G = 3'd2,
        RA_GAIN_B = 3'd3,
        RA_OFS_R  = 3'd4,
        RA_OFS_G  = 3'd5,
        RA_OFS_B  = 3'd6,
        RA_RSVD   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/sps_frame_rx.sv
// Module: receive side of the serial frame. Finds serial clock edges with the
// system clock, counts bits, captures direction, address, strap and data,
// and raises a one-cycle write strobe when the last data bit arrives.
// Assumes sclk, sen_n, sdi and mode_pin are synchronous to clk.
module sps_frame_rx #(
    parameter int FRAME_BITS = 16,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sen_n,
    input  logic              sdi,
    input  logic              mode_pin,
    output logic              sclk_fall,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              rd_req,
    output logic [ADDR_W-1:0] addr,
    output logic              mode4,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data
);
    localparam int DATA_START = FRAME_BITS - DATA_W;

    logic              sclk_q;
    logic              sclk_rise;
    logic [DATA_W-2:0] data_sh;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sclk_rise = sclk & ~sclk_q & ~sen_n;
    assign sclk_fall = ~sclk & sclk_q & ~sen_n;

    // Bit counter: cleared while the frame is closed, saturates at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || sen_n)
            bit_cnt <= '0;
        else if (sclk_rise && bit_cnt < CNT_W'(FRAME_BITS))
            bit_cnt <= bit_cnt + 1'b1;
    end

    // Field capture: direction, address bits, wiring strap and data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req  <= 1'b0;
            addr    <= '0;
            mode4   <= 1'b0;
            data_sh <= '0;
        end else if (sclk_rise) begin
            if (bit_cnt == '0) rd_req <= sdi;
            if (bit_cnt == CNT_W'(1)) mode4 <= mode_pin;
            for (int k = 0; k < ADDR_W; k++)
                if (bit_cnt == CNT_W'(k + 1)) addr[k] <= sdi;
            for (int k = 0; k < DATA_W - 1; k++)
                if (bit_cnt == CNT_W'(DATA_START + k)) data_sh[k] <= sdi;
        end
    end

    assign wr_stb  = sclk_rise && !rd_req && (bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign wr_data = {sdi, data_sh};
endmodule

// File: rtl/sps_reg_bank.sv
// Module: register file of the port. One configuration register with the
// power-down write rule, N_CH gain and N_CH offset registers, and a
// combinational read mux. Addresses beyond the last offset are ignored.
module sps_reg_bank #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int N_CH   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        cfg_q,
    output logic [N_CH*DATA_W-1:0]   gain_q,
    output logic [N_CH*DATA_W-1:0]   ofs_q
);
    localparam int GAIN_BASE = 1;
    localparam int OFS_BASE  = GAIN_BASE + N_CH;

    logic [DATA_W-1:0] gain_r [N_CH];
    logic [DATA_W-1:0] ofs_r  [N_CH];

    // Configuration register: a set top bit only raises power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_stb && wr_addr == '0) begin
            if (wr_data[DATA_W-1]) cfg_q[DATA_W-1] <= 1'b1;
            else                   cfg_q <= wr_data;
        end
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        // Per-channel gain and offset registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gain_r[ch] <= '0;
                ofs_r[ch]  <= '0;
            end else if (wr_stb) begin
                if (wr_addr == ADDR_W'(GAIN_BASE + ch)) gain_r[ch] <= wr_data;
                if (wr_addr == ADDR_W'(OFS_BASE + ch))  ofs_r[ch]  <= wr_data;
            end
        end
        assign gain_q[ch*DATA_W +: DATA_W] = gain_r[ch];
        assign ofs_q[ch*DATA_W +: DATA_W]  = ofs_r[ch];
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = cfg_q;
        for (int ch = 0; ch < N_CH; ch++) begin
            if (rd_addr == ADDR_W'(GAIN_BASE + ch)) rd_data = gain_r[ch];
            if (rd_addr == ADDR_W'(OFS_BASE + ch))  rd_data = ofs_r[ch];
        end
    end
endmodule

// File: rtl/sps_read_tx.sv
// Module: read return path. On each falling serial clock edge of the data
// phase of a read it presents the next register bit, LSB first, on the line
// picked by the wiring strap. Releases both lines when the frame closes.
module sps_read_tx #(
    parameter int FRAME_BITS = 16,
    parameter int DATA_W     = 8,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_n,
    input  logic              sclk_fall,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              rd_req,
    input  logic              mode4,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo_out,
    output logic              sdo_oe
);
    localparam int DATA_START = FRAME_BITS - DATA_W;

    logic drive_q;
    logic bit_q;

    // Drive state and current bit, updated on falling serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n || sen_n) begin
            drive_q <= 1'b0;
            bit_q   <= 1'b0;
        end else if (sclk_fall) begin
            drive_q <= 1'b0;
            for (int k = 0; k < DATA_W; k++)
                if (rd_req && bit_cnt == CNT_W'(DATA_START + k)) begin
                    drive_q <= 1'b1;
                    bit_q   <= rd_data[k];
                end
        end
    end

    assign sdio_out = bit_q;
    assign sdo_out  = bit_q;
    assign sdio_oe  = drive_q & ~mode4;
    assign sdo_oe   = drive_q & mode4;
endmodule

// File: rtl/sps_cfg_port.sv
// Module: top of the serial configuration port. Joins receiver, register
// bank and read path, and decodes configuration fields for the datapath.
// Assumes all serial inputs are synchronous to clk.
module sps_cfg_port
    import sps_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int GAIN_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   sen_n,
    input  logic                   sdio_in,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    input  logic                   sdo_in,
    output logic                   sdo_out,
    output logic                   sdo_oe,
    output logic [DATA_W-1:0]      cfg_word,
    output logic [N_CH*GAIN_W-1:0] gain_codes,
    output logic [N_CH*DATA_W-1:0] offset_codes,
    output logic                   power_down,
    output logic                   span_hi,
    output logic                   cds_en,
    output logic [1:0]             in_sel,
    output logic                   mon_off
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic              sclk_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rd_req;
    logic [ADDR_W-1:0] addr;
    logic              mode4;
    logic              wr_stb;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [N_CH*DATA_W-1:0] gain_full;

    sps_frame_rx #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdi(sdio_in),
        .mode_pin(sdo_in), .sclk_fall(sclk_fall), .bit_cnt(bit_cnt),
        .rd_req(rd_req), .addr(addr), .mode4(mode4), .wr_stb(wr_stb),
        .wr_data(wr_data)
    );

    sps_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(addr),
        .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data),
        .cfg_q(cfg_word), .gain_q(gain_full), .ofs_q(offset_codes)
    );

    sps_read_tx #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk_fall(sclk_fall),
        .bit_cnt(bit_cnt), .rd_req(rd_req), .mode4(mode4), .rd_data(rd_data),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_gain
        assign gain_codes[ch*GAIN_W +: GAIN_W] = gain_full[ch*DATA_W +: GAIN_W];
    end

    assign span_hi    = cfg_word[0];
    assign cds_en     = cfg_word[1];
    assign in_sel     = cfg_word[3:2];
    assign mon_off    = cfg_word[5];
    assign power_down = cfg_word[DATA_W-1];
endmodule

// File: rtl/sps_cfg_port_chk.sv
// Module: protocol checker bound to the port top. Observes ports only.
module sps_cfg_port_chk #(
    parameter int DW = 8,
    parameter int GW = 18,
    parameter int OW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sen_n,
    input logic          sdio_oe,
    input logic          sdo_oe,
    input logic          power_down,
    input logic [DW-1:0] cfg_word,
    input logic [GW-1:0] gain_codes,
    input logic [OW-1:0] offset_codes
);
    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdio_oe, sdo_oe})); // R11

    AST_HIZ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n |=> (!sdio_oe && !sdo_oe)); // R5

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n |=> ($stable(cfg_word) && $stable(gain_codes) && $stable(offset_codes))); // R6

    AST_PD_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_down) |-> $stable(cfg_word[DW-2:0])); // R8
endmodule

bind sps_cfg_port sps_cfg_port_chk #(
    .DW(8), .GW(18), .OW(24)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
    .power_down(power_down), .cfg_word(cfg_word), .gain_codes(gain_codes),
    .offset_codes(offset_codes)
);

// File: tb/sps_cfg_port_tb_top.sv
// Bench: behavioural register model compared with the exports every clock,
// plus pin-level checks of read data and drive enables inside each frame.
module sps_cfg_port_tb_top;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sen_n = 1'b1, sdio_in = 1'b0, sdo_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [7:0]  cfg_word;
    logic [17:0] gain_codes;
    logic [23:0] offset_codes;
    logic power_down, span_hi, cds_en, mon_off;
    logic [1:0] in_sel;

    int n_chk = 0, n_bad = 0;
    bit cmp_en = 0;
    bit done = 0;
    logic [7:0] mreg [8];

    always #2.5 clk = ~clk;

    sps_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_in(sdo_in), .sdo_out(sdo_out),
        .sdo_oe(sdo_oe), .cfg_word(cfg_word), .gain_codes(gain_codes),
        .offset_codes(offset_codes), .power_down(power_down), .span_hi(span_hi),
        .cds_en(cds_en), .in_sel(in_sel), .mon_off(mon_off)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] exp_exports();
        logic [63:0] v;
        v = {mreg[0], mreg[3][5:0], mreg[2][5:0], mreg[1][5:0],
             mreg[6], mreg[5], mreg[4], mreg[0][7], mreg[0][0], mreg[0][1],
             mreg[0][3:2], mreg[0][5]};
        return v;
    endfunction

    function automatic logic [63:0] act_exports();
        return {cfg_word, gain_codes, offset_codes, power_down, span_hi, cds_en,
                in_sel, mon_off};
    endfunction

    // Model of a committed write: R1 map, R7 reserved, R8 power-down rule.
    task automatic model_write(input bit [2:0] a, input bit [7:0] d);
        if (a == 3'd7) return;
        if (a == 3'd0 && d[7]) mreg[0][7] = 1'b1;
        else mreg[a] = d;
    endtask

    // Continuous comparison of all exports with the model (R1 R8 R9 R12).
    initial begin
        forever begin
            @(negedge clk);
            if (cmp_en)
                check(act_exports() == exp_exports(), "R1 R8 R9 R12 exports",
                      act_exports(), exp_exports());
        end
    end

    // One frame of nbits bits; rw=1 reads, m4 picks the wiring strap.
    task automatic frame(input bit rw, input bit [2:0] a, input bit [7:0] d,
                         input bit m4, input int nbits);
        logic [15:0] f;
        logic [7:0]  rexp;
        f = {d, 4'b0000, a, rw};
        rexp = mreg[a];
        sdo_in = m4;
        sen_n = 1'b0;
        waitn(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdio_in = (rw && i >= 8) ? 1'b0 : f[i];
            waitn(HALF);
            if (rw && i >= 8) begin
                if (m4) begin
                    check(sdo_oe && !sdio_oe, "R4 drive", {sdo_oe, sdio_oe}, 2'b10);
                    check(sdo_out == rexp[i-8], "R2 data", sdo_out, rexp[i-8]);
                end else begin
                    check(sdio_oe && !sdo_oe, "R3 drive", {sdio_oe, sdo_oe}, 2'b10);
                    check(sdio_out == rexp[i-8], "R2 data", sdio_out, rexp[i-8]);
                end
            end else begin
                check(!sdio_oe && !sdo_oe, "R5 idle", {sdio_oe, sdo_oe}, 0);
            end
            sclk = 1'b1;
            if (i == 15 && !rw) begin
                @(posedge clk);
                #1 model_write(a, d);
            end
            waitn(HALF);
            sclk = 1'b0;
            waitn(HALF);
        end
        sen_n = 1'b1;
        @(posedge clk);
        #1 check(!sdio_oe && !sdo_oe, "R5 release", {sdio_oe, sdo_oe}, 0);
        waitn(HALF);
    endtask

    task automatic rd_all(input bit m4);
        for (int a = 0; a < 8; a++) frame(1'b1, 3'(a), 8'h00, m4, 16);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) mreg[k] = 8'h00;
        waitn(4);
        rst_n = 1'b1;
        waitn(2);
        // R10: reset values and decoded defaults.
        check(cfg_word == 8'h00 && !power_down && !span_hi && !cds_en &&
              in_sel == 2'b00 && !mon_off, "R10 reset", act_exports(), 0);
        check(gain_codes == '0 && offset_codes == '0, "R10 reset regs",
              {gain_codes, offset_codes}, 0);
        cmp_en = 1;

        // R1 R12: configuration and channel registers, both wirings.
        frame(1'b0, 3'd0, 8'h2E, 1'b0, 16);
        frame(1'b0, 3'd1, 8'hC5, 1'b0, 16);   // R9 reserved bits set
        frame(1'b0, 3'd2, 8'h3F, 1'b1, 16);
        frame(1'b0, 3'd3, 8'h81, 1'b0, 16);   // R9
        frame(1'b0, 3'd4, 8'h80, 1'b1, 16);
        frame(1'b0, 3'd5, 8'hFF, 1'b0, 16);
        frame(1'b0, 3'd6, 8'h7F, 1'b1, 16);
        // R2 R3 R4: read every address over both wirings.
        rd_all(1'b0);
        rd_all(1'b1);

        // R7: reserved address write ignored, read returns zero.
        frame(1'b0, 3'd7, 8'hAA, 1'b0, 16);
        frame(1'b1, 3'd7, 8'h00, 1'b1, 16);

        // R6: write cut off one bit early, then a read cut mid data phase.
        frame(1'b0, 3'd1, 8'h12, 1'b0, 15);
        frame(1'b0, 3'd6, 8'h00, 1'b1, 3);
        frame(1'b1, 3'd4, 8'h00, 1'b0, 12);
        frame(1'b1, 3'd1, 8'h00, 1'b0, 16);
        frame(1'b1, 3'd6, 8'h00, 1'b1, 16);

        // R8: power-down keeps low bits, clearing reloads all bits.
        frame(1'b0, 3'd0, 8'h81, 1'b0, 16);
        check(cfg_word == 8'hAE && power_down, "R8 pd keep", cfg_word, 8'hAE);
        frame(1'b1, 3'd0, 8'h00, 1'b1, 16);
        frame(1'b0, 3'd0, 8'h05, 1'b1, 16);
        check(cfg_word == 8'h05 && !power_down && span_hi && in_sel == 2'b01,
              "R8 R12 restore", cfg_word, 8'h05);
        frame(1'b1, 3'd0, 8'h00, 1'b0, 16);

        done = 1;
        cmp_en = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule